// File: doc/BRIEF.md
# Indirect Pointer Access Unit

This block keeps a small set of data-memory pointers and turns register-space accesses to per-pointer virtual registers into real data-memory reads and writes. Each pointer is 12 bits wide and is stored as a low byte and a high byte. Each pointer has five access windows: plain indirect, post-decrement, post-increment, pre-increment, and signed-offset indexed. The offset for the indexed window comes from a W operand supplied by the core. The core reaches the block through an 8-bit register-space port. The block drives a 12-bit data-memory port whose read path is combinational.

Pointer n occupies eight register addresses starting at `BASE + 8*n`, with `BASE` = E0h by default. The slot offsets are: 0 indirect, 1 post-decrement, 2 post-increment, 3 pre-increment, 4 indexed, 5 low byte, 6 high byte, 7 unused. Pointer updates carry or borrow across the full 12 bits, and the block has no flag outputs.

A pointer can hold an address in the top 256-byte page (address bits 11:8 all ones) whose low byte falls inside this window. Such a target is resolved locally and never reaches memory. If it names a pointer byte, that byte is read or written. Otherwise the read returns zero and the write is dropped.

Top module: `ptr_indirect_unit`

## Requirements
- R1: After reset every pointer reads back as zero through its low-byte slot (offset 5) and its high-byte slot (offset 6).
- R2: The low-byte and high-byte slots can be written and read directly. The high byte keeps 4 bits, so bits 7:4 of a high-byte read are always zero.
- R3: The indirect slot (offset 0) reads or writes memory at the pointer value and leaves the pointer unchanged.
- R4: The post-increment slot (offset 2) accesses memory at the old value and then adds one across the full 12 bits. FFh in the low byte carries into the high byte, and FFFh wraps to 000h.
- R5: The post-decrement slot (offset 1) accesses memory at the old value and then subtracts one across the full 12 bits, borrowing from the high byte.
- R6: The pre-increment slot (offset 3) adds one to the pointer first and accesses memory at the new value.
- R7: The indexed slot (offset 4) accesses memory at the pointer plus W, where W is taken as signed 8-bit and the sum wraps modulo 4096. The pointer is unchanged.
- R8: When the target lies in the top page and names a non-byte slot of any pointer, a read returns 00h and a write has no effect. Neither case strobes memory, but the accessing pointer's own auto-modify still applies.
- R9: An indirect write whose target is a pointer byte slot stores the data into that byte and applies no increment or decrement. An indirect read of such a target returns the byte.
- R10: The memory strobes are raised only for virtual-slot accesses whose target lies outside the window. Memory write data equals the core write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 8 | Register-space address |
| reg_re_i | input | 1 | Register read strobe |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| w_i | input | 8 | W operand for the indexed slot |
| reg_rdata_o | output | 8 | Register read data, zero when no read strobe |
| mem_addr_o | output | 12 | Data-memory address |
| mem_re_o | output | 1 | Data-memory read strobe |
| mem_we_o | output | 1 | Data-memory write strobe |
| mem_wdata_o | output | 8 | Data-memory write data |
| mem_rdata_i | input | 8 | Data-memory read data (combinational) |

## Verification
The assertions check the following on every cycle:
- No memory strobe ever carries an address inside the local window.
- Memory writes only ever carry the core's write data.
- High-byte reads keep their upper nibble clear.
- A read through post-increment advances exactly that pointer by one.
- A read through the indexed slot leaves every pointer unchanged.

Only the bench scenarios can show the rest. These include carry and borrow across the byte boundary and wrap at FFFh. They also include the exact effective addresses for negative and positive W. The remaining scenarios cover the zero result and dropped write when a pointer names another pointer's virtual slot, and the plain byte store without auto-modify when a pointer names its own low byte.

// File: rtl/ptr_pkg.sv
package ptr_pkg;
  typedef enum logic [2:0] {
    SLOT_IND   = 3'd0,
    SLOT_PDEC  = 3'd1,
    SLOT_PINC  = 3'd2,
    SLOT_PREI  = 3'd3,
    SLOT_PLUSW = 3'd4,
    SLOT_LO    = 3'd5,
    SLOT_HI    = 3'd6,
    SLOT_NONE  = 3'd7
  } slot_e;

  function automatic logic is_virt(slot_e k);
    return (k == SLOT_IND) || (k == SLOT_PDEC) || (k == SLOT_PINC) ||
           (k == SLOT_PREI) || (k == SLOT_PLUSW);
  endfunction

  function automatic logic is_byte(slot_e k);
    return (k == SLOT_LO) || (k == SLOT_HI);
  endfunction
endpackage

// File: rtl/ptr_slot_dec.sv
module ptr_slot_dec #(
  parameter int unsigned NUM_PTR = 3,
  parameter logic [7:0]  BASE    = 8'hE0,
  parameter int unsigned IW      = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
  input  logic [7:0]      addr_i,
  input  logic            page_i,
  output logic            hit_o,
  output logic [IW-1:0]   idx_o,
  output ptr_pkg::slot_e  kind_o
);
  localparam int unsigned SPAN = 8 * NUM_PTR;

  logic [7:0] off;
  assign off    = addr_i - BASE;
  assign hit_o  = page_i && (32'(off) < SPAN);
  assign idx_o  = IW'(off[7:3]);
  assign kind_o = ptr_pkg::slot_e'(off[2:0]);
endmodule

// File: rtl/ptr_ea_calc.sv
module ptr_ea_calc #(
  parameter int unsigned PA_W = 12
) (
  input  logic [PA_W-1:0] ptr_i,
  input  ptr_pkg::slot_e  kind_i,
  input  logic [7:0]      w_i,
  output logic [PA_W-1:0] ea_o,
  output logic [PA_W-1:0] next_o,
  output logic            upd_o
);
  import ptr_pkg::*;

  logic [PA_W-1:0] inc, dec, sx;
  assign inc = ptr_i + PA_W'(1);
  assign dec = ptr_i - PA_W'(1);
  assign sx  = {{(PA_W-8){w_i[7]}}, w_i};

  always_comb begin
    ea_o   = ptr_i;
    next_o = ptr_i;
    upd_o  = 1'b0;
    unique case (kind_i)
      SLOT_PDEC:  begin next_o = dec; upd_o = 1'b1; end
      SLOT_PINC:  begin next_o = inc; upd_o = 1'b1; end
      SLOT_PREI:  begin ea_o = inc; next_o = inc; upd_o = 1'b1; end
      SLOT_PLUSW: ea_o = ptr_i + sx;
      default:    ;
    endcase
  end
endmodule

// File: rtl/ptr_bank.sv
module ptr_bank #(
  parameter int unsigned NUM_PTR = 3,
  parameter int unsigned PA_W    = 12,
  parameter int unsigned IW      = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          upd_en_i,
  input  logic [IW-1:0]                 upd_idx_i,
  input  logic [PA_W-1:0]               upd_val_i,
  input  logic                          bw_en_i,
  input  logic [IW-1:0]                 bw_idx_i,
  input  logic                          bw_hi_i,
  input  logic [7:0]                    bw_val_i,
  output logic [NUM_PTR-1:0][PA_W-1:0]  ptr_o
);
  localparam int unsigned HW = PA_W - 8;

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    logic [PA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= '0;
      end else begin
        if (upd_en_i && upd_idx_i == IW'(g)) q <= upd_val_i;
        // byte store wins over auto-modify
        if (bw_en_i && bw_idx_i == IW'(g)) begin
          if (bw_hi_i) q[PA_W-1:8] <= bw_val_i[HW-1:0];
          else         q[7:0]      <= bw_val_i;
        end
      end
    end
    assign ptr_o[g] = q;
  end
endmodule

// File: rtl/ptr_indirect_unit.sv
module ptr_indirect_unit #(
  parameter int unsigned NUM_PTR = 3,
  parameter logic [7:0]  BASE    = 8'hE0,
  parameter int unsigned PA_W    = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [7:0]      reg_addr_i,
  input  logic            reg_re_i,
  input  logic            reg_we_i,
  input  logic [7:0]      reg_wdata_i,
  input  logic [7:0]      w_i,
  output logic [7:0]      reg_rdata_o,
  output logic [PA_W-1:0] mem_addr_o,
  output logic            mem_re_o,
  output logic            mem_we_o,
  output logic [7:0]      mem_wdata_o,
  input  logic [7:0]      mem_rdata_i
);
  import ptr_pkg::*;

  localparam int unsigned IW = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1;
  localparam int unsigned HW = PA_W - 8;

  logic [NUM_PTR-1:0][PA_W-1:0] ptr_q;

  logic          c_hit, t_hit;
  logic [IW-1:0] c_idx, t_idx;
  slot_e         c_kind, t_kind;

  logic [PA_W-1:0] sel_ptr, ea, nxt;
  logic            ea_upd;
  logic            virt, d_byte, t_byte;
  logic            bw_en, bw_hi, upd_en;
  logic [IW-1:0]   bw_idx;

  function automatic logic [7:0] byte_of(logic [PA_W-1:0] p, logic hi);
    return hi ? {{(8-HW){1'b0}}, p[PA_W-1:8]} : p[7:0];
  endfunction

  ptr_slot_dec #(.NUM_PTR(NUM_PTR), .BASE(BASE), .IW(IW)) u_core_dec (
    .addr_i (reg_addr_i),
    .page_i (1'b1),
    .hit_o  (c_hit),
    .idx_o  (c_idx),
    .kind_o (c_kind)
  );

  assign sel_ptr = ptr_q[c_idx];
  assign virt    = (reg_re_i || reg_we_i) && c_hit && is_virt(c_kind);
  assign d_byte  = c_hit && is_byte(c_kind);

  ptr_ea_calc #(.PA_W(PA_W)) u_ea (
    .ptr_i  (sel_ptr),
    .kind_i (c_kind),
    .w_i    (w_i),
    .ea_o   (ea),
    .next_o (nxt),
    .upd_o  (ea_upd)
  );

  ptr_slot_dec #(.NUM_PTR(NUM_PTR), .BASE(BASE), .IW(IW)) u_tgt_dec (
    .addr_i (ea[7:0]),
    .page_i (&ea[PA_W-1:8]),
    .hit_o  (t_hit),
    .idx_o  (t_idx),
    .kind_o (t_kind)
  );

  assign t_byte = virt && t_hit && is_byte(t_kind);

  assign bw_en  = reg_we_i && (d_byte || t_byte);
  assign bw_idx = d_byte ? c_idx : t_idx;
  assign bw_hi  = d_byte ? (c_kind == SLOT_HI) : (t_kind == SLOT_HI);
  assign upd_en = virt && ea_upd && !(reg_we_i && t_byte);

  ptr_bank #(.NUM_PTR(NUM_PTR), .PA_W(PA_W), .IW(IW)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_en_i  (upd_en),
    .upd_idx_i (c_idx),
    .upd_val_i (nxt),
    .bw_en_i   (bw_en),
    .bw_idx_i  (bw_idx),
    .bw_hi_i   (bw_hi),
    .bw_val_i  (reg_wdata_i),
    .ptr_o     (ptr_q)
  );

  assign mem_addr_o  = ea;
  assign mem_re_o    = virt && reg_re_i && !t_hit;
  assign mem_we_o    = virt && reg_we_i && !t_hit;
  assign mem_wdata_o = reg_wdata_i;

  always_comb begin
    reg_rdata_o = 8'h00;
    if (reg_re_i) begin
      if (d_byte)      reg_rdata_o = byte_of(sel_ptr, c_kind == SLOT_HI);
      else if (virt) begin
        if (!t_hit)      reg_rdata_o = mem_rdata_i;
        else if (t_byte) reg_rdata_o = byte_of(ptr_q[t_idx], t_kind == SLOT_HI);
      end
    end
  end
endmodule

// File: rtl/ptr_indirect_unit_chk.sv
module ptr_indirect_unit_chk #(
  parameter int unsigned NUM_PTR = 3,
  parameter logic [7:0]  BASE    = 8'hE0,
  parameter int unsigned PA_W    = 12
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [7:0]                   reg_addr_i,
  input logic                         reg_re_i,
  input logic                         reg_we_i,
  input logic [7:0]                   reg_wdata_i,
  input logic [7:0]                   reg_rdata_o,
  input logic [PA_W-1:0]              mem_addr_o,
  input logic                         mem_re_o,
  input logic                         mem_we_o,
  input logic [7:0]                   mem_wdata_o,
  input logic [NUM_PTR-1:0][PA_W-1:0] ptr_q
);
  localparam int unsigned LAST = 32'(BASE) + 8 * NUM_PTR;

  logic       a_in, m_in;
  logic [2:0] a_slot;
  int unsigned a_idx;
  assign a_in   = (32'(reg_addr_i) >= 32'(BASE)) && (32'(reg_addr_i) < LAST);
  assign a_slot = reg_addr_i[2:0] - BASE[2:0];
  assign a_idx  = (32'(reg_addr_i) - 32'(BASE)) / 8;
  assign m_in   = (&mem_addr_o[PA_W-1:8]) && (32'(mem_addr_o[7:0]) >= 32'(BASE)) &&
                  (32'(mem_addr_o[7:0]) < LAST);

  logic              pinc_q;
  int unsigned       idx_q;
  logic [PA_W-1:0]   val_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pinc_q <= 1'b0;
      idx_q  <= 0;
      val_q  <= '0;
    end else begin
      pinc_q <= reg_re_i && !reg_we_i && a_in && a_slot == 3'd2;
      idx_q  <= a_in ? a_idx : 0;
      val_q  <= ptr_q[a_in ? a_idx : 0];
    end
  end

  AST_NO_MEM_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o || mem_we_o) |-> !m_in); // R8

  AST_MEM_WDATA_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (reg_we_i && mem_wdata_o == reg_wdata_i)); // R10

  AST_MEM_RD_VIRT_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |-> (reg_re_i && a_in && a_slot <= 3'd4)); // R10

  AST_HI_NIBBLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_i && a_in && a_slot == 3'd6) |-> reg_rdata_o[7:4] == 4'h0); // R2

  AST_POSTINC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pinc_q |-> ptr_q[idx_q] == val_q + PA_W'(1)); // R4

  AST_PLUSW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_i && !reg_we_i && a_in && a_slot == 3'd4) |=> $stable(ptr_q)); // R7
endmodule

bind ptr_indirect_unit ptr_indirect_unit_chk #(
  .NUM_PTR(NUM_PTR), .BASE(BASE), .PA_W(PA_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_addr_i  (reg_addr_i),
  .reg_re_i    (reg_re_i),
  .reg_we_i    (reg_we_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .mem_addr_o  (mem_addr_o),
  .mem_re_o    (mem_re_o),
  .mem_we_o    (mem_we_o),
  .mem_wdata_o (mem_wdata_o),
  .ptr_q       (ptr_q)
);

// File: tb/ptr_indirect_unit_tb.sv
`timescale 1ns/1ps
module ptr_indirect_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0, reg_wdata = '0, w = '0;
  logic        reg_re = 1'b0, reg_we = 1'b0;
  logic [7:0]  reg_rdata, mem_wdata, mem_rdata;
  logic [11:0] mem_addr;
  logic        mem_re, mem_we;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  // memory model: data is a fixed function of the address
  assign mem_rdata = mem_addr[7:0] ^ {mem_addr[11:8], 4'h5};

  ptr_indirect_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(reg_addr), .reg_re_i(reg_re),
    .reg_we_i(reg_we), .reg_wdata_i(reg_wdata), .w_i(w), .reg_rdata_o(reg_rdata),
    .mem_addr_o(mem_addr), .mem_re_o(mem_re), .mem_we_o(mem_we),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  typedef struct packed {
    logic [7:0]  a;
    logic        we;
    logic        re;
    logic [7:0]  wd;
    logic [7:0]  w;
    logic [7:0]  rd;
    logic        mre;
    logic        mwe;
    logic [11:0] ma;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 38;
  localparam vec_t VEC [0:NV-1] = '{
    '{8'hE5,1'b1,1'b0,8'hFF,8'h00,8'h00,1'b0,1'b0,12'h000,4'd2},  // R2
    '{8'hE6,1'b1,1'b0,8'hA3,8'h00,8'h00,1'b0,1'b0,12'h000,4'd2},  // R2
    '{8'hE6,1'b0,1'b1,8'h00,8'h00,8'h03,1'b0,1'b0,12'h000,4'd2},  // R2
    '{8'hE5,1'b0,1'b1,8'h00,8'h00,8'hFF,1'b0,1'b0,12'h000,4'd2},  // R2
    '{8'hE2,1'b0,1'b1,8'h00,8'h00,8'hCA,1'b1,1'b0,12'h3FF,4'd4},  // R4
    '{8'hE6,1'b0,1'b1,8'h00,8'h00,8'h04,1'b0,1'b0,12'h000,4'd4},  // R4
    '{8'hE5,1'b0,1'b1,8'h00,8'h00,8'h00,1'b0,1'b0,12'h000,4'd4},  // R4
    '{8'hE1,1'b0,1'b1,8'h00,8'h00,8'h45,1'b1,1'b0,12'h400,4'd5},  // R5
    '{8'hE5,1'b0,1'b1,8'h00,8'h00,8'hFF,1'b0,1'b0,12'h000,4'd5},  // R5
    '{8'hE6,1'b0,1'b1,8'h00,8'h00,8'h03,1'b0,1'b0,12'h000,4'd5},  // R5
    '{8'hE3,1'b0,1'b1,8'h00,8'h00,8'h45,1'b1,1'b0,12'h400,4'd6},  // R6
    '{8'hE5,1'b0,1'b1,8'h00,8'h00,8'h00,1'b0,1'b0,12'h000,4'd6},  // R6
    '{8'hE0,1'b0,1'b1,8'h00,8'h00,8'h45,1'b1,1'b0,12'h400,4'd3},  // R3
    '{8'hE0,1'b1,1'b0,8'h5A,8'h00,8'h00,1'b0,1'b1,12'h400,4'd3},  // R3
    '{8'hE5,1'b0,1'b1,8'h00,8'h00,8'h00,1'b0,1'b0,12'h000,4'd3},  // R3
    '{8'hE4,1'b0,1'b1,8'h00,8'hFE,8'hCB,1'b1,1'b0,12'h3FE,4'd7},  // R7
    '{8'hE5,1'b0,1'b1,8'h00,8'h00,8'h00,1'b0,1'b0,12'h000,4'd7},  // R7
    '{8'hED,1'b1,1'b0,8'h05,8'h00,8'h00,1'b0,1'b0,12'h000,4'd7},  // R7
    '{8'hEE,1'b1,1'b0,8'h00,8'h00,8'h00,1'b0,1'b0,12'h000,4'd7},  // R7
    '{8'hEC,1'b0,1'b1,8'h00,8'h80,8'h70,1'b1,1'b0,12'hF85,4'd7},  // R7
    '{8'hEC,1'b0,1'b1,8'h00,8'h7F,8'h81,1'b1,1'b0,12'h084,4'd7},  // R7
    '{8'hED,1'b0,1'b1,8'h00,8'h00,8'h05,1'b0,1'b0,12'h000,4'd7},  // R7
    '{8'hED,1'b1,1'b0,8'hE0,8'h00,8'h00,1'b0,1'b0,12'h000,4'd8},  // R8
    '{8'hEE,1'b1,1'b0,8'h0F,8'h00,8'h00,1'b0,1'b0,12'h000,4'd8},  // R8
    '{8'hE8,1'b0,1'b1,8'h00,8'h00,8'h00,1'b0,1'b0,12'h000,4'd8},  // R8
    '{8'hE8,1'b1,1'b0,8'h77,8'h00,8'h00,1'b0,1'b0,12'h000,4'd8},  // R8
    '{8'hE5,1'b0,1'b1,8'h00,8'h00,8'h00,1'b0,1'b0,12'h000,4'd8},  // R8
    '{8'hE6,1'b0,1'b1,8'h00,8'h00,8'h04,1'b0,1'b0,12'h000,4'd8},  // R8
    '{8'hEA,1'b0,1'b1,8'h00,8'h00,8'h00,1'b0,1'b0,12'h000,4'd8},  // R8
    '{8'hED,1'b0,1'b1,8'h00,8'h00,8'hE1,1'b0,1'b0,12'h000,4'd8},  // R8
    '{8'hF5,1'b1,1'b0,8'hF5,8'h00,8'h00,1'b0,1'b0,12'h000,4'd9},  // R9
    '{8'hF6,1'b1,1'b0,8'h0F,8'h00,8'h00,1'b0,1'b0,12'h000,4'd9},  // R9
    '{8'hF1,1'b1,1'b0,8'h33,8'h00,8'h00,1'b0,1'b0,12'h000,4'd9},  // R9
    '{8'hF5,1'b0,1'b1,8'h00,8'h00,8'h33,1'b0,1'b0,12'h000,4'd9},  // R9
    '{8'hF6,1'b0,1'b1,8'h00,8'h00,8'h0F,1'b0,1'b0,12'h000,4'd9},  // R9
    '{8'hED,1'b1,1'b0,8'hF5,8'h00,8'h00,1'b0,1'b0,12'h000,4'd9},  // R9
    '{8'hE8,1'b0,1'b1,8'h00,8'h00,8'h33,1'b0,1'b0,12'h000,4'd9},  // R9
    '{8'hF0,1'b1,1'b0,8'h66,8'h00,8'h00,1'b0,1'b1,12'hF33,4'd10}  // R10
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive at negedge, outputs settle combinationally, edge commits pointer updates
  task automatic op(input logic [7:0] a, input logic we, re, input logic [7:0] wd, wv);
    @(negedge clk);
    reg_addr = a; reg_we = we; reg_re = re; reg_wdata = wd; w = wv;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    reg_we = 1'b0; reg_re = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    op(a, 1'b0, 1'b1, 8'h00, 8'h00);
    chk(req, $sformatf("rdata @%h", a), 32'(reg_rdata), 32'(exp));
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset values
    rd_chk("R1", 8'hE5, 8'h00);
    rd_chk("R1", 8'hEE, 8'h00);
    chk("R1", "mem_re idle", 32'(mem_re), 0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VEC[i].req);
      op(VEC[i].a, VEC[i].we, VEC[i].re, VEC[i].wd, VEC[i].w);
      if (VEC[i].re) chk(tag, $sformatf("rdata v%0d", i), 32'(reg_rdata), 32'(VEC[i].rd));
      chk(tag, $sformatf("mem_re v%0d", i), 32'(mem_re), 32'(VEC[i].mre));
      chk(tag, $sformatf("mem_we v%0d", i), 32'(mem_we), 32'(VEC[i].mwe));
      if (VEC[i].mre || VEC[i].mwe)
        chk(tag, $sformatf("mem_addr v%0d", i), 32'(mem_addr), 32'(VEC[i].ma));
      if (VEC[i].mwe)
        chk("R10", $sformatf("mem_wdata v%0d", i), 32'(mem_wdata), 32'(VEC[i].wd));
    end

    // R4: full 12-bit wrap FFFh -> 000h
    op(8'hE5, 1'b1, 1'b0, 8'hFF, 8'h00);
    op(8'hE6, 1'b1, 1'b0, 8'h0F, 8'h00);
    op(8'hE2, 1'b0, 1'b1, 8'h00, 8'h00);
    chk("R4", "wrap mem_addr", 32'(mem_addr), 32'h0FFF);
    chk("R4", "wrap rdata", 32'(reg_rdata), 32'h0A);
    rd_chk("R4", 8'hE5, 8'h00);
    rd_chk("R4", 8'hE6, 8'h00);

    // R2: upper nibble of high byte dropped on write
    op(8'hF6, 1'b1, 1'b0, 8'hF9, 8'h00);
    rd_chk("R2", 8'hF6, 8'h09);

    // R1: reset again clears all pointers
    idle();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd_chk("R1", 8'hE5, 8'h00);
    rd_chk("R1", 8'hE6, 8'h00);
    rd_chk("R1", 8'hED, 8'h00);
    rd_chk("R1", 8'hF5, 8'h00);
    rd_chk("R1", 8'hF6, 8'h00);
    idle();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule